// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block collects one non-maskable request and seven maskable requests, from peripherals inside the chip or from external pins, and presents a single winner to the processor. A rising edge on a request line latches a pending bit. Each maskable source has a mask bit and a three-bit priority, where level 0 is the most urgent. The block shows the winning source index and its level on its output. The processor answers with an acknowledge when it takes the request, and with an end-of-service strobe when the handler returns.

The block keeps a record of which priority levels are in service. A new maskable request reaches the processor only if its level is strictly more urgent than every level already in service, so handlers can nest. The non-maskable request takes no notice of masks and levels. It preempts any maskable handler, and it cannot nest with itself. A small register port gives software the priority fields, the masks, a pending view with write-one-to-clear, and the in-service record.

Top module: `nest_intc`

## Requirements
- R1: After reset, req_valid is 0, every mask bit is 1 (masked), every priority field is 7, and no pending or in-service bit is set.
- R2: A maskable pending bit is set by a rising edge of its irq_in line, seen between two clock edges. It stays set until that source is acknowledged or software writes a 1 to its bit at address 2. If a new edge arrives in the same cycle as a clear, the pending bit stays set.
- R3: A pending source whose mask bit (address 1, bit i, 1 = masked) is set is never forwarded.
- R4: A maskable source is forwarded only if its priority number is strictly lower than the lowest-numbered level in service. No maskable source is forwarded while the non-maskable handler is in service.
- R5: Among the eligible maskable sources, the one with the lowest priority number wins, and the lower source index breaks a tie. req_vec carries the index and req_prio carries its level.
- R6: When ack is high while req_valid is high, the winner's pending bit is cleared and its level is marked in service. An ack while req_valid is low has no effect.
- R7: An eoi pulse ends the non-maskable handler if it is in service. Otherwise it clears the lowest-numbered in-service level. If eoi and ack occur in the same cycle, eoi is applied first.
- R8: A rising edge on nmi_in latches an NMI pending bit. While it is pending and no NMI is in service, the block presents req_nmi=1, req_vec=7 and req_prio=0, whatever the masks and levels in service. A second NMI stays pending until eoi ends the first.
- R9: The register map is as follows. Address 0 holds priority field i at bits [3i+2:3i]. Address 1 holds the masks in bits [6:0]. Address 2 reads the maskable pending bits in [6:0] and the NMI pending bit in bit 7; a write clears the bits [6:0] that are written as 1. Address 3 reads the in-service levels in [7:0] and the NMI in-service bit in bit 8, and ignores writes. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 7 | Maskable request lines |
| nmi_in | input | 1 | Non-maskable request line |
| ack | input | 1 | Processor takes the presented request |
| eoi | input | 1 | Handler finished |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | output | 1 | A request is presented |
| req_nmi | output | 1 | The presented request is the NMI |
| req_vec | output | 3 | Winning source index, 7 for NMI |
| req_prio | output | 3 | Level of the presented request |

## Verification
The bench goes after equal priorities, where a design that compares with "less or equal" in the wrong direction would pick the higher index. It tests a request whose level equals the one in service, which a non-strict comparison would wrongly let preempt its own level. It drives an NMI while a maskable handler runs and a second NMI during the first, where a broken design would either hide the NMI behind the level threshold or nest it. It also tests eoi with several levels in service, where clearing the wrong bit leaves a stale level that blocks later requests, and edges that coincide with a software clear, which a clear-wins design would lose.

// File: rtl/nest_intc.sv
module nest_intc #(
  parameter int NSRC = 7,
  parameter int PW   = 3,
  parameter int AW   = 3,
  parameter int DW   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           irq_in,
  input  logic                      nmi_in,
  input  logic                      ack,
  input  logic                      eoi,
  input  logic                      reg_we,
  input  logic [AW-1:0]             reg_addr,
  input  logic [DW-1:0]             reg_wdata,
  output logic [DW-1:0]             reg_rdata,
  output logic                      req_valid,
  output logic                      req_nmi,
  output logic [$clog2(NSRC+1)-1:0] req_vec,
  output logic [PW-1:0]             req_prio
);
  localparam int NLVL = 1 << PW;
  localparam int VW   = $clog2(NSRC+1);
  localparam int TW   = PW + 1;

  logic [NSRC-1:0]    irq_q, pend, mask;
  logic [NSRC*PW-1:0] prio;
  logic [NLVL-1:0]    isv;
  logic               nmi_q, nmi_pend, nmi_act;

  logic [NSRC-1:0] rise;
  logic            nmi_rise, take, take_nmi;

  assign rise     = irq_in & ~irq_q;
  assign nmi_rise = nmi_in & ~nmi_q;

  logic [TW-1:0]   thr;
  logic [TW-1:0]   best;
  logic [VW-1:0]   best_idx;
  logic            any;

  always_comb begin
    thr = TW'(NLVL);
    for (int l = NLVL-1; l >= 0; l--)
      if (isv[l]) thr = TW'(l);
  end

  always_comb begin
    best     = TW'(NLVL);
    best_idx = '0;
    any      = 1'b0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (pend[i] && !mask[i] && ({1'b0, prio[i*PW +: PW]} <= best)) begin
        best     = {1'b0, prio[i*PW +: PW]};
        best_idx = VW'(i);
        any      = 1'b1;
      end
    end
  end

  logic mask_ok;
  assign mask_ok   = any && !nmi_act && (best < thr);
  assign take_nmi  = nmi_pend && !nmi_act;
  assign req_valid = take_nmi || mask_ok;
  assign req_nmi   = take_nmi;
  assign req_vec   = take_nmi ? VW'(NSRC) : best_idx;
  assign req_prio  = take_nmi ? '0 : best[PW-1:0];
  assign take      = ack && req_valid;

  logic wr_clr;
  assign wr_clr = reg_we && (reg_addr == AW'(2));

  logic [NLVL-1:0] isv_e;
  assign isv_e = (eoi && !nmi_act) ? (isv & (isv - NLVL'(1))) : isv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q    <= '0;
      nmi_q    <= 1'b0;
      pend     <= '0;
      mask     <= '1;
      prio     <= '1;
      isv      <= '0;
      nmi_pend <= 1'b0;
      nmi_act  <= 1'b0;
    end else begin
      irq_q <= irq_in;
      nmi_q <= nmi_in;
      if (reg_we && reg_addr == AW'(0)) prio <= reg_wdata[NSRC*PW-1:0];
      if (reg_we && reg_addr == AW'(1)) mask <= reg_wdata[NSRC-1:0];
      begin
        logic [NSRC-1:0] p;
        logic [NLVL-1:0] s;
        p = pend;
        s = isv_e;
        if (wr_clr) p = p & ~reg_wdata[NSRC-1:0];
        if (take && !take_nmi) begin
          p[best_idx] = 1'b0;
          s[best[PW-1:0]] = 1'b1;
        end
        pend <= p | rise;
        isv  <= s;
      end
      nmi_pend <= (nmi_pend && !(take && take_nmi)) || nmi_rise;
      if (take && take_nmi) nmi_act <= 1'b1;
      else if (eoi && nmi_act) nmi_act <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(0): reg_rdata[NSRC*PW-1:0] = prio;
      AW'(1): reg_rdata[NSRC-1:0]    = mask;
      AW'(2): reg_rdata[NSRC:0]      = {nmi_pend, pend};
      AW'(3): reg_rdata[NLVL:0]      = {nmi_act, isv};
      default: reg_rdata = '0;
    endcase
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !req_valid); // R1
  AST_MASK_HONORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_nmi) |-> (!mask[req_vec] && pend[req_vec])); // R3
  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_nmi) |-> ((isv & ((NLVL'(2) << req_prio) - NLVL'(1))) == '0 && !nmi_act)); // R4
  AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_valid && !req_nmi) |=> isv[$past(req_prio)]); // R6
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && !nmi_act && isv != '0) |=> $countones(isv) == $countones($past(isv)) - 1); // R7
  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_nmi |-> !nmi_act); // R8
  AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_nmi) |=> nmi_act); // R8
endmodule

// File: tb/tb_nest_intc.sv
`timescale 1ns/1ps
module tb_nest_intc;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] irq_in = '0;
  logic nmi_in = 1'b0, ack = 1'b0, eoi = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic req_valid, req_nmi;
  logic [2:0] req_vec, req_prio;

  always #2 clk = ~clk;

  nest_intc dut (.clk, .rst_n, .irq_in, .nmi_in, .ack, .eoi, .reg_we, .reg_addr,
                 .reg_wdata, .reg_rdata, .req_valid, .req_nmi, .req_vec, .req_prio);

  int vecs = 0, errs = 0;

  logic [6:0]  m_pend, m_mask, m_prev;
  logic [20:0] m_prio;
  logic [7:0]  m_isv;
  logic        m_nact, m_npend, m_nprev;
  logic        e_valid, e_nmi;
  logic [2:0]  e_vec, e_prio;

  function automatic int lowest_isv(logic [7:0] s);
    for (int l = 0; l < 8; l++) if (s[l]) return l;
    return 8;
  endfunction

  always_comb begin
    int bp, bi, th;
    bp = 8; bi = 0;
    th = lowest_isv(m_isv);
    for (int i = 0; i < 7; i++)
      if (m_pend[i] && !m_mask[i] && int'(m_prio[3*i +: 3]) < bp) begin
        bp = int'(m_prio[3*i +: 3]); bi = i;
      end
    if (m_npend && !m_nact) begin
      e_valid = 1'b1; e_nmi = 1'b1; e_vec = 3'd7; e_prio = 3'd0;
    end else if (bp < 8 && bp < th && !m_nact) begin
      e_valid = 1'b1; e_nmi = 1'b0; e_vec = 3'(bi); e_prio = 3'(bp);
    end else begin
      e_valid = 1'b0; e_nmi = 1'b0; e_vec = 3'd0; e_prio = 3'd0;
    end
  end

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return {11'b0, m_prio};
      3'd1: return {25'b0, m_mask};
      3'd2: return {24'b0, m_npend, m_pend};
      3'd3: return {23'b0, m_nact, m_isv};
      default: return 32'b0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pend = '0; m_mask = '1; m_prev = '0; m_prio = '1; m_isv = '0;
    m_nact = 0; m_npend = 0; m_nprev = 0;
  endtask

  task automatic step(string tag);
    logic [6:0] np; logic [7:0] ns; logic nact, nnp; logic [20:0] npr; logic [6:0] nm;
    np = m_pend; ns = m_isv; nact = m_nact; nnp = m_npend; npr = m_prio; nm = m_mask;
    if (reg_we && reg_addr == 3'd0) npr = reg_wdata[20:0];
    if (reg_we && reg_addr == 3'd1) nm = reg_wdata[6:0];
    if (reg_we && reg_addr == 3'd2) np = np & ~reg_wdata[6:0];
    if (eoi) begin
      if (m_nact) nact = 0;
      else if (lowest_isv(ns) < 8) ns[lowest_isv(ns)] = 1'b0;
    end
    if (ack && e_valid) begin
      if (e_nmi) begin nnp = 0; nact = 1; end
      else begin np[e_vec] = 1'b0; ns[e_prio] = 1'b1; end
    end
    np = np | (irq_in & ~m_prev);
    nnp = nnp | (nmi_in & ~m_nprev);
    @(posedge clk);
    m_pend = np; m_isv = ns; m_nact = nact; m_npend = nnp; m_prio = npr; m_mask = nm;
    m_prev = irq_in; m_nprev = nmi_in;
    #1;
    check(tag, {29'b0, req_valid, req_nmi, 1'b0}, {29'b0, e_valid, e_nmi, 1'b0});
    if (e_valid) check(tag, {26'b0, req_vec, req_prio}, {26'b0, e_vec, e_prio});
    check("R9", reg_rdata, exp_rd(reg_addr));
    @(negedge clk);
    ack = 0; eoi = 0; reg_we = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, string tag);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step(tag);
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #0;
    check("R1", {31'b0, req_valid}, 32'd0);
    reg_addr = 3'd0; #1 check("R1", reg_rdata, 32'h001F_FFFF);
    reg_addr = 3'd1; #1 check("R1", reg_rdata, 32'h0000_007F);
    reg_addr = 3'd3; #1 check("R1", reg_rdata, 32'h0);
    @(negedge clk);
    // R3: masked source stays hidden
    irq_in = 7'h01; step("R3");
    check("R3", {31'b0, req_valid}, 32'd0);
    irq_in = 7'h00;
    // R9 program priorities: s0=5 s1=2 s2=2 s3=0 others 7
    wr(3'd0, {11'b0, 3'd7, 3'd7, 3'd7, 3'd0, 3'd2, 3'd2, 3'd5}, "R9");
    wr(3'd1, 32'h0, "R9");
    // R5 tie between s1 and s2 -> s1
    irq_in = 7'h06; step("R2");
    irq_in = 7'h00; step("R5");
    check("R5", {29'b0, req_vec}, 32'd1);
    ack = 1; reg_addr = 3'd3; step("R6");
    check("R4", {31'b0, req_valid}, 32'd0);
    // R4 equal level blocked, level 0 preempts
    irq_in = 7'h08; step("R4");
    check("R4", {26'b0, req_vec, req_prio}, {26'b0, 3'd3, 3'd0});
    irq_in = 7'h00; ack = 1; step("R6");
    eoi = 1; step("R7");
    eoi = 1; step("R7");
    check("R5", {29'b0, req_vec}, 32'd2);
    // R3 mask s2 while pending, plus R6 ack with nothing shown
    wr(3'd1, 32'h04, "R3");
    ack = 1; reg_addr = 3'd2; step("R6");
    // R8 NMI preempts a maskable handler and does not nest
    wr(3'd1, 32'h0, "R3");
    ack = 1; step("R6");
    nmi_in = 1; step("R8");
    check("R8", {29'b0, req_nmi, 2'b0}, 32'd4);
    nmi_in = 0; ack = 1; step("R8");
    nmi_in = 1; step("R8");
    nmi_in = 0; irq_in = 7'h08; step("R8");
    irq_in = 0; eoi = 1; step("R8");
    ack = 1; step("R8");
    eoi = 1; step("R7");
    eoi = 1; step("R7");
    eoi = 1; step("R7");
    // R2 software clear coinciding with a new edge
    irq_in = 7'h10; step("R2");
    irq_in = 7'h00; step("R2");
    irq_in = 7'h10; reg_addr = 3'd2; wr(3'd2, 32'h7F, "R2");
    irq_in = 7'h00; wr(3'd2, 32'h10, "R2");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      irq_in = ($urandom % 4 == 0) ? 7'($urandom) : irq_in;
      nmi_in = ($urandom % 40 == 0) ? ~nmi_in : nmi_in;
      ack = ($urandom % 3 == 0);
      eoi = ($urandom % 5 == 0);
      if ($urandom % 25 == 0) begin
        reg_we = 1;
        reg_addr = 3'($urandom % 4);
        reg_wdata = (reg_addr == 3'd1) ? 32'($urandom % 2 ? 0 : $urandom) : $urandom;
      end else reg_addr = 3'($urandom % 8);
      step("R5");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule